// File: doc/BRIEF.md
# S/PDIF Receiver Status Monitor

This block sits behind an S/PDIF biphase decoder and clock-recovery front end. It receives one decoded subframe per accepted cycle: a 24-bit audio word, the validity bit, the channel-status bit, a marker for the first subframe of a channel-status block, and a parity or transmission-error indication. It pairs subframes into stereo frames and replaces a corrupted frame with silence or with the last clean pair. It also assembles the consumer channel-status block from the first subframe of each frame and decodes its fields.

Eight event sources feed a latched interrupt status register: loss of lock, invalid subframe, transmission error, non-audio change, copyright change, de-emphasis change, channel-status block update and sample-rate change. A per-flag select vector decides which events latch and which error flags trigger concealment. The active-low interrupt stays low while any bit is latched. A status-read strobe clears the latched bits.

Top module: `spdif_status_mon`

## Requirements
- R1: After reset, int_n is 1, int_stat is 0, out_valid is 0 and all decoded channel-status fields are 0.
- R2: The channel-status bit of the subframe with sf_chan=0 that carries sf_blk_start is block bit 0. Each later such subframe supplies the next bit, up to bit 39, and later bits are ignored. Once bit 39 arrives, the block is stored and decoded as follows: non-audio = bit 1, copy-permitted = bit 2, pre-emphasis = bit 3, category = bits 15:8, source = bits 19:16, channel number = bits 23:20, max word length = bit 32, word length = bits 35:33. The lowest bit index is the field LSB in each case.
- R3: Status bit 6 (block update) latches when a completed block differs from the stored block. An identical block latches nothing.
- R4: Status bits 3, 4 and 5 latch when a completed block changes block bit 1, 2 or 3 respectively.
- R5: Status bit 1 latches on an accepted subframe with sf_v=1. Status bit 2 latches on an accepted subframe with sf_par_err=1.
- R6: Status bit 0 latches on any change of lock_lost. Status bit 7 latches on a cycle with rate_evt=1.
- R7: An event latches only when its flag_sel bit is 1. Latched bits hold until a read. int_n is 0 exactly when int_stat is nonzero.
- R8: A cycle with stat_rd=1 clears int_stat. Events selected in that same cycle remain set.
- R9: A subframe with sf_chan=1 that follows one with sf_chan=0 completes a frame. out_valid pulses in the next cycle with out_left and out_right.
- R10: If either subframe of a frame has sf_v=1 while flag_sel[1]=1, or sf_par_err=1 while flag_sel[2]=1, and fill_last=0, both outputs are 0.
- R11: Under the same error condition with fill_last=1, the outputs repeat the last clean frame. That frame is 0 after reset.
- R12: An error whose flag_sel bit is 0 does not conceal the frame, which passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sf_valid | input | 1 | Subframe present this cycle |
| sf_chan | input | 1 | 0 = first subframe of frame, 1 = second |
| sf_audio | input | 24 | Audio word |
| sf_v | input | 1 | Validity bit (1 = invalid) |
| sf_c | input | 1 | Channel-status bit |
| sf_blk_start | input | 1 | First subframe of channel-status block |
| sf_par_err | input | 1 | Parity or transmission error |
| lock_lost | input | 1 | Front end not locked (level) |
| rate_evt | input | 1 | Received-rate change pulse |
| flag_sel | input | 8 | Per-flag select for latching and concealment |
| fill_last | input | 1 | Concealment: 0 zeros, 1 last clean frame |
| stat_rd | input | 1 | Status read strobe, clears int_stat |
| out_valid | output | 1 | Cleaned frame valid |
| out_left | output | 24 | Cleaned first-subframe sample |
| out_right | output | 24 | Cleaned second-subframe sample |
| int_n | output | 1 | Active-low interrupt |
| int_stat | output | 8 | Latched interrupt status |
| cs_block | output | 40 | Stored channel-status block |
| cs_nonaudio | output | 1 | Block bit 1 |
| cs_copy_ok | output | 1 | Block bit 2 |
| cs_preemph | output | 1 | Block bit 3 |
| cs_category | output | 8 | Block bits 15:8 |
| cs_source | output | 4 | Block bits 19:16 |
| cs_chnum | output | 4 | Block bits 23:20 |
| cs_maxwl | output | 1 | Block bit 32 |
| cs_wordlen | output | 3 | Block bits 35:33 |

## Verification
Clean frames with distinct left and right words check pairing and channel order. Frames with the error on the first subframe are sent under zero fill and last-good fill, and frames with the error on the second subframe under last-good fill; these tell the two fill modes apart and show that both samples are replaced. The same errors are repeated with their select bits cleared to show that concealment depends on the select. Channel-status blocks are sent three ways: as a first block, as an exact repeat, and with only the category changed. Together these separate the block-update event from the three field-change events.

// File: rtl/spdif_mon_pkg.sv
`timescale 1ns/1ps
package spdif_mon_pkg;
  localparam int NFLAGS      = 8;
  localparam int CS_USED     = 40;
  localparam int FLG_UNLOCK  = 0;
  localparam int FLG_INVALID = 1;
  localparam int FLG_TERR    = 2;
  localparam int FLG_NONAUD  = 3;
  localparam int FLG_COPY    = 4;
  localparam int FLG_DEEMPH  = 5;
  localparam int FLG_CSUPD   = 6;
  localparam int FLG_RATE    = 7;
endpackage

// File: rtl/spdif_cs_assembler.sv
`timescale 1ns/1ps
module spdif_cs_assembler #(
  parameter int CS_BITS = spdif_mon_pkg::CS_USED
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sf_valid,
  input  logic               sf_chan,
  input  logic               sf_c,
  input  logic               sf_blk_start,
  output logic [CS_BITS-1:0] cs_block,
  output logic               upd_evt,
  output logic               nonaud_evt,
  output logic               copy_evt,
  output logic               deemph_evt
);
  localparam int CW = $clog2(CS_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(CS_BITS);
  localparam logic [CW-1:0] LAST = CW'(CS_BITS - 1);

  logic [CW-1:0]      cnt_q, cnt_d;
  logic [CS_BITS-1:0] sh_q, sh_d, blk_q, blk_d;
  logic               take, done;

  always_comb begin
    take       = sf_valid && !sf_chan;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    blk_d      = blk_q;
    done       = 1'b0;
    upd_evt    = 1'b0;
    nonaud_evt = 1'b0;
    copy_evt   = 1'b0;
    deemph_evt = 1'b0;
    if (take) begin
      if (sf_blk_start) begin
        sh_d    = '0;
        sh_d[0] = sf_c;
        cnt_d   = CW'(1);
      end else if (cnt_q < FULL) begin
        sh_d[cnt_q] = sf_c;
        cnt_d       = cnt_q + 1'b1;
        done        = (cnt_q == LAST);
      end
    end
    if (done) begin
      blk_d      = sh_d;
      upd_evt    = (sh_d != blk_q);
      nonaud_evt = (sh_d[1] != blk_q[1]);
      copy_evt   = (sh_d[2] != blk_q[2]);
      deemph_evt = (sh_d[3] != blk_q[3]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= FULL;
      sh_q  <= '0;
      blk_q <= '0;
    end else begin
      if (take) begin
        cnt_q <= cnt_d;
        sh_q  <= sh_d;
      end
      if (done) blk_q <= blk_d;
    end
  end

  assign cs_block = blk_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);  // R2
  AST_UPD_CHANGES_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (cs_block != $past(cs_block)));  // R3
  AST_NO_UPD_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_evt) |=> (cs_block == $past(cs_block)));  // R3
endmodule

// File: rtl/spdif_frame_conceal.sv
`timescale 1ns/1ps
module spdif_frame_conceal #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sf_valid,
  input  logic          sf_chan,
  input  logic [DW-1:0] sf_audio,
  input  logic          sf_v,
  input  logic          sf_par_err,
  input  logic          sel_invalid,
  input  logic          sel_terr,
  input  logic          fill_last,
  output logic          out_valid,
  output logic [DW-1:0] out_left,
  output logic [DW-1:0] out_right
);
  logic          pend_q, pend_d, lbad_q, lbad_d;
  logic [DW-1:0] lbuf_q, lbuf_d, gl_q, gl_d, gr_q, gr_d, ol_d, or_d;
  logic          ov_d, sub_bad, acc_l, acc_r, frame_bad;

  always_comb begin
    sub_bad   = (sf_v && sel_invalid) || (sf_par_err && sel_terr);
    acc_l     = sf_valid && !sf_chan;
    acc_r     = sf_valid && sf_chan && pend_q;
    frame_bad = lbad_q || sub_bad;
    pend_d    = pend_q;
    lbad_d    = lbad_q;
    lbuf_d    = lbuf_q;
    gl_d      = gl_q;
    gr_d      = gr_q;
    ov_d      = 1'b0;
    ol_d      = out_left;
    or_d      = out_right;
    if (acc_l) begin
      pend_d = 1'b1;
      lbuf_d = sf_audio;
      lbad_d = sub_bad;
    end
    if (acc_r) begin
      pend_d = 1'b0;
      ov_d   = 1'b1;
      if (frame_bad) begin
        ol_d = fill_last ? gl_q : '0;
        or_d = fill_last ? gr_q : '0;
      end else begin
        ol_d = lbuf_q;
        or_d = sf_audio;
        gl_d = lbuf_q;
        gr_d = sf_audio;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      lbad_q    <= 1'b0;
      lbuf_q    <= '0;
      gl_q      <= '0;
      gr_q      <= '0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= ov_d;
      if (acc_l || acc_r) begin
        pend_q <= pend_d;
        lbad_q <= lbad_d;
        lbuf_q <= lbuf_d;
      end
      if (acc_r) begin
        gl_q      <= gl_d;
        gr_q      <= gr_d;
        out_left  <= ol_d;
        out_right <= or_d;
      end
    end
  end

  AST_OUT_AFTER_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(sf_valid && sf_chan));  // R9
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_r && frame_bad && !fill_last) |=> (out_left == '0 && out_right == '0));  // R10
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_r && !frame_bad) |=> (out_right == $past(sf_audio)));  // R12
endmodule

// File: rtl/spdif_irq_ctrl.sv
`timescale 1ns/1ps
module spdif_irq_ctrl #(
  parameter int NF = spdif_mon_pkg::NFLAGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] ev,
  input  logic [NF-1:0] sel,
  input  logic          rd,
  output logic [NF-1:0] stat,
  output logic          int_n
);
  logic [NF-1:0] stat_d, hit;

  always_comb begin
    hit    = ev & sel;
    stat_d = (rd ? '0 : stat) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_d;
  end

  assign int_n = ~(|stat);

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ((stat & $past(stat)) == $past(stat)));  // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit == '0) |=> (stat == '0));  // R8
  AST_NO_UNSEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> ((stat & ~$past(sel)) == '0));  // R7
endmodule

// File: rtl/spdif_status_mon.sv
`timescale 1ns/1ps
module spdif_status_mon #(
  parameter int DW      = 24,
  parameter int CS_BITS = spdif_mon_pkg::CS_USED,
  parameter int NF      = spdif_mon_pkg::NFLAGS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sf_valid,
  input  logic               sf_chan,
  input  logic [DW-1:0]      sf_audio,
  input  logic               sf_v,
  input  logic               sf_c,
  input  logic               sf_blk_start,
  input  logic               sf_par_err,
  input  logic               lock_lost,
  input  logic               rate_evt,
  input  logic [NF-1:0]      flag_sel,
  input  logic               fill_last,
  input  logic               stat_rd,
  output logic               out_valid,
  output logic [DW-1:0]      out_left,
  output logic [DW-1:0]      out_right,
  output logic               int_n,
  output logic [NF-1:0]      int_stat,
  output logic [CS_BITS-1:0] cs_block,
  output logic               cs_nonaudio,
  output logic               cs_copy_ok,
  output logic               cs_preemph,
  output logic [7:0]         cs_category,
  output logic [3:0]         cs_source,
  output logic [3:0]         cs_chnum,
  output logic               cs_maxwl,
  output logic [2:0]         cs_wordlen
);
  import spdif_mon_pkg::*;

  logic          lock_q;
  logic          upd_evt, nonaud_evt, copy_evt, deemph_evt;
  logic [NF-1:0] ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_lost;
  end

  spdif_cs_assembler #(.CS_BITS(CS_BITS)) u_cs (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan(sf_chan),
    .sf_c(sf_c), .sf_blk_start(sf_blk_start), .cs_block(cs_block),
    .upd_evt(upd_evt), .nonaud_evt(nonaud_evt), .copy_evt(copy_evt),
    .deemph_evt(deemph_evt)
  );

  spdif_frame_conceal #(.DW(DW)) u_fill (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan(sf_chan),
    .sf_audio(sf_audio), .sf_v(sf_v), .sf_par_err(sf_par_err),
    .sel_invalid(flag_sel[FLG_INVALID]), .sel_terr(flag_sel[FLG_TERR]),
    .fill_last(fill_last), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right)
  );

  always_comb begin
    ev              = '0;
    ev[FLG_UNLOCK]  = lock_lost ^ lock_q;
    ev[FLG_INVALID] = sf_valid && sf_v;
    ev[FLG_TERR]    = sf_valid && sf_par_err;
    ev[FLG_NONAUD]  = nonaud_evt;
    ev[FLG_COPY]    = copy_evt;
    ev[FLG_DEEMPH]  = deemph_evt;
    ev[FLG_CSUPD]   = upd_evt;
    ev[FLG_RATE]    = rate_evt;
  end

  spdif_irq_ctrl #(.NF(NF)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .sel(flag_sel), .rd(stat_rd),
    .stat(int_stat), .int_n(int_n)
  );

  assign cs_nonaudio = cs_block[1];
  assign cs_copy_ok  = cs_block[2];
  assign cs_preemph  = cs_block[3];
  assign cs_category = cs_block[15:8];
  assign cs_source   = cs_block[19:16];
  assign cs_chnum    = cs_block[23:20];
  assign cs_maxwl    = cs_block[32];
  assign cs_wordlen  = cs_block[35:33];

  AST_INT_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_n && !stat_rd) |=> !int_n);  // R7
  AST_UNLOCK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_lost != lock_q && flag_sel[FLG_UNLOCK]) |=> int_stat[FLG_UNLOCK]);  // R6
endmodule

// File: tb/spdif_status_mon_tb.sv
`timescale 1ns/1ps
module spdif_status_mon_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sf_valid, sf_chan, sf_v, sf_c, sf_blk_start, sf_par_err;
  logic [23:0] sf_audio;
  logic        lock_lost, rate_evt, fill_last, stat_rd;
  logic [7:0]  flag_sel;
  logic        out_valid, int_n, cs_nonaudio, cs_copy_ok, cs_preemph, cs_maxwl;
  logic [23:0] out_left, out_right;
  logic [7:0]  int_stat, cs_category;
  logic [39:0] cs_block;
  logic [3:0]  cs_source, cs_chnum;
  logic [2:0]  cs_wordlen;

  int checks = 0;
  int fails  = 0;
  logic [47:0] exp_q[$];
  logic [47:0] last_good;

  always #2 clk = ~clk;

  spdif_status_mon u_dut (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_chan(sf_chan),
    .sf_audio(sf_audio), .sf_v(sf_v), .sf_c(sf_c), .sf_blk_start(sf_blk_start),
    .sf_par_err(sf_par_err), .lock_lost(lock_lost), .rate_evt(rate_evt),
    .flag_sel(flag_sel), .fill_last(fill_last), .stat_rd(stat_rd),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .int_n(int_n), .int_stat(int_stat), .cs_block(cs_block),
    .cs_nonaudio(cs_nonaudio), .cs_copy_ok(cs_copy_ok), .cs_preemph(cs_preemph),
    .cs_category(cs_category), .cs_source(cs_source), .cs_chnum(cs_chnum),
    .cs_maxwl(cs_maxwl), .cs_wordlen(cs_wordlen)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop on every produced frame (R9..R12)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check("R9 unexpected frame", {out_left, out_right}, 48'h0);
      else check("R9-R12 frame", {out_left, out_right}, exp_q.pop_front());
    end
  end

  task automatic sub(input logic ch, input logic [23:0] d, input logic v,
                     input logic pe, input logic c, input logic st);
    @(negedge clk);
    sf_valid = 1'b1; sf_chan = ch; sf_audio = d; sf_v = v;
    sf_par_err = pe; sf_c = c; sf_blk_start = st;
    @(negedge clk);
    sf_valid = 1'b0; sf_v = 1'b0; sf_par_err = 1'b0; sf_blk_start = 1'b0;
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r,
                            input logic vl, input logic vr, input logic pl,
                            input logic pr, input logic c, input logic st);
    logic bad;
    bad = ((vl | vr) & flag_sel[1]) | ((pl | pr) & flag_sel[2]);
    if (bad) exp_q.push_back(fill_last ? last_good : 48'h0);
    else begin
      exp_q.push_back({l, r});
      last_good = {l, r};
    end
    sub(1'b0, l, vl, pl, c, st);
    sub(1'b1, r, vr, pr, c, 1'b0);
  endtask

  task automatic send_block(input logic [39:0] cs);
    for (int i = 0; i < 40; i++)
      send_frame(24'(i * 4099 + 7), 24'(i * 911 + 3), 1'b0, 1'b0, 1'b0, 1'b0,
                 cs[i], i == 0);
  endtask

  task automatic read_stat();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [39:0] blk;
    rst_n = 1'b0; sf_valid = 1'b0; sf_chan = 1'b0; sf_audio = '0; sf_v = 1'b0;
    sf_c = 1'b0; sf_blk_start = 1'b0; sf_par_err = 1'b0; lock_lost = 1'b0;
    rate_evt = 1'b0; flag_sel = 8'hFF; fill_last = 1'b0; stat_rd = 1'b0;
    last_good = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 int_n", int_n, 1);
    check("R1 int_stat", int_stat, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 cs_block", cs_block, 0);

    // R9 clean frames
    send_frame(24'h123456, 24'hABCDEF, 0, 0, 0, 0, 0, 0);
    send_frame(24'hFFFFFF, 24'h000001, 0, 0, 0, 0, 0, 0);
    check("R7 no event keeps int_n high", int_n, 1);

    // R10 zero fill on invalid left subframe, R5 invalid flag
    send_frame(24'h111111, 24'h222222, 1, 0, 0, 0, 0, 0);
    check("R5 invalid latched", int_stat, 8'h02);
    check("R7 int_n low", int_n, 0);
    read_stat();
    check("R8 read clears", int_stat, 8'h00);
    check("R8 int_n released", int_n, 1);

    // R11 last-good fill on transmission error in right subframe
    fill_last = 1'b1;
    send_frame(24'h0A0B0C, 24'h0D0E0F, 0, 0, 0, 0, 0, 0);
    send_frame(24'h333333, 24'h444444, 0, 0, 0, 1, 0, 0);
    send_frame(24'h555555, 24'h666666, 1, 0, 0, 0, 0, 0);
    check("R5 terr and invalid latched", int_stat, 8'h06);
    read_stat();

    // R12 unselected errors pass through, R7 nothing latches
    flag_sel = 8'h00;
    send_frame(24'h777777, 24'h888888, 1, 1, 1, 0, 0, 0);
    check("R7 unselected no latch", int_stat, 8'h00);
    check("R7 unselected int_n", int_n, 1);
    flag_sel = 8'hFF;
    fill_last = 1'b0;

    // R2/R3/R4 first channel-status block
    blk = '0;
    blk[1] = 1; blk[2] = 1; blk[3] = 1;
    blk[15:8] = 8'h5A; blk[19:16] = 4'h3; blk[23:20] = 4'h9;
    blk[32] = 1; blk[35:33] = 3'b101;
    send_block(blk);
    check("R2 cs_block", cs_block, blk);
    check("R2 nonaudio", cs_nonaudio, 1);
    check("R2 copy", cs_copy_ok, 1);
    check("R2 preemph", cs_preemph, 1);
    check("R2 category", cs_category, 8'h5A);
    check("R2 source", cs_source, 4'h3);
    check("R2 chnum", cs_chnum, 4'h9);
    check("R2 maxwl", cs_maxwl, 1);
    check("R2 wordlen", cs_wordlen, 3'b101);
    check("R3 R4 events", int_stat, 8'h78);
    read_stat();

    // R3 identical block latches nothing
    send_block(blk);
    check("R3 same block no event", int_stat, 8'h00);

    // R3 category-only change: update without R4 field events
    blk[15:8] = 8'hC3;
    send_block(blk);
    check("R3 update only", int_stat, 8'h40);
    check("R2 new category", cs_category, 8'hC3);
    read_stat();

    // R6 unlock edge and rate pulse
    @(negedge clk); lock_lost = 1'b1;
    @(negedge clk);
    check("R6 unlock latched", int_stat, 8'h01);
    rate_evt = 1'b1;
    @(negedge clk); rate_evt = 1'b0;
    check("R6 rate latched", int_stat, 8'h81);

    // R8 read with simultaneous event
    stat_rd = 1'b1; rate_evt = 1'b1;
    @(negedge clk); stat_rd = 1'b0; rate_evt = 1'b0;
    check("R8 same-cycle event kept", int_stat, 8'h80);
    read_stat();

    // R7 only selected flags latch
    flag_sel = 8'h80;
    lock_lost = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 unlock unselected", int_stat, 8'h00);
    check("R7 int_n stays high", int_n, 1);

    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule